// File: doc/BRIEF.md
# Event-Driven PWM Waveform Generator

This block drives two PWM outputs from one 16-bit timer. The timer runs in one of two modes. In sawtooth mode it counts down from the period value to zero and then reloads. In triangle mode it climbs from zero to the period value and falls back to zero. Each clock cycle the block compares the count with the period and with two compare values. From these compares it forms six direction-qualified event pulses.

Each output has its own table of 2-bit action codes, one code per event. The output register changes only when an event with a non-zero code fires. When several such events land in the same cycle, a fixed priority decides which one acts. Two independent select masks route any set of events to an interrupt pulse and to a converter-trigger pulse.

A sync input clears the counter, so several generators can start together on a shared time base. All inputs are plain control levels, and the block has no streaming data path, so it has no valid/ready handshake.

Top module: `pwm_event_gen`

## Requirements
- R1: While `rst_n` is low, `count` is 0, `count_up`, `events`, `pwm_a`, `pwm_b`, `irq` and `adc_trig` are all 0 (with `updown` low), and the direction state is "up".
- R2: With `updown` low and `run_en` high, `count` goes from 0 to `period` on the next edge; otherwise it decrements by one per edge.
- R3: With `updown` high and `run_en` high:
  - While rising, `count` increments until it reaches or passes `period`. It then turns to `period-1` and starts falling.
  - While falling, it decrements to 0 and then turns to 1 and starts rising.
  - If `period` is 0, `count` stays at 0.
- R4: `count_up` is high only in triangle mode while rising, and it is always low in sawtooth mode.
- R5: `events[0]` (zero) is high in any cycle where `run_en` is high and `count` is 0. `events[1]` (load) is high in any cycle where `run_en` is high and `count` equals `period`.
- R6: Compare events depend on the direction:
  - `events[2]`/`events[4]` mark an A/B compare match while `count_up` is high.
  - `events[3]`/`events[5]` mark an A/B compare match while `count_up` is low.
  - In sawtooth mode, bits 2 and 4 never fire.
- R7: Action field k of `act_a`/`act_b` (bits 2k+1:2k) applies to event k, and the output changes on the next edge. The codes are 0 = keep, 1 = toggle, 2 = drive low, 3 = drive high.
- R8: Only events with a non-zero code take part. Among those, the higher event index wins, which gives the order B compare > A compare > load > zero.
- R9: `irq` is high for one cycle after any cycle in which `events & irq_sel` is non-zero, and low otherwise.
- R10: `adc_trig` follows the same rule using `trig_sel`, independently of `irq_sel`.
- R11: `sync` high clears `count` to 0 and sets the direction to rising on the next edge, regardless of `run_en`.
- R12: With `run_en` low and `sync` low, `count` holds and `events` is 0.
- R13: With `period`=399 in sawtooth mode, an output set high on load and low on A-down with compare 299 is high 100 of every 400 cycles. The B output, using compare 99, is high 300 of every 400 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter run enable |
| updown | input | 1 | 1 = triangle mode, 0 = sawtooth mode |
| sync | input | 1 | Counter clear for a shared time base |
| period | input | 16 | Load (period) value |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| act_a | input | 12 | Action codes for output A, 2 bits per event |
| act_b | input | 12 | Action codes for output B, 2 bits per event |
| irq_sel | input | 6 | Events that raise `irq` |
| trig_sel | input | 6 | Events that raise `adc_trig` |
| count | output | 16 | Timer value |
| count_up | output | 1 | Direction flag, high while rising |
| events | output | 6 | Event pulses: zero, load, A up, A down, B up, B down |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| irq | output | 1 | Interrupt pulse |
| adc_trig | output | 1 | Converter trigger pulse |

## Verification
The embedded assertions watch several properties on every cycle:
- the sawtooth reload to the period value;
- the one-step climb in triangle mode;
- the counter clear after sync;
- the frozen count while stopped;
- the absence of up-compare events in sawtooth mode;
- outputs that hold when no event fires, and a high output after a drive-high code;
- a silent `irq` or `adc_trig` after a cycle with no selected event.

Other behaviours only show up in the bench's scenarios, which compare every port against a cycle model over random configurations:
- the triangle turnaround points and the zero-period case;
- the priority between coincident events;
- the exact duty cycles over whole periods.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int NUM_EV = 6;
  localparam int ACT_W  = 2 * NUM_EV;

  // event indices: priority rises with index
  localparam int EV_ZERO  = 0;
  localparam int EV_LOAD  = 1;
  localparam int EV_AUP   = 2;
  localparam int EV_ADOWN = 3;
  localparam int EV_BUP   = 4;
  localparam int EV_BDOWN = 5;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } act_e;

  function automatic logic apply_act(input logic cur, input act_e code);
    case (code)
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_evt_counter.sv
module pwm_evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             updown,
  input  logic             sync,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             count_up
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      up_q  <= 1'b1;
    end else if (sync) begin
      count <= '0;
      up_q  <= 1'b1;
    end else if (run_en) begin
      if (!updown) begin
        count <= (count == '0) ? period : count - ONE;
      end else if (up_q) begin
        if (count >= period) begin
          up_q  <= 1'b0;
          count <= (period == '0) ? '0 : period - ONE;
        end else begin
          count <= count + ONE;
        end
      end else begin
        if (count == '0) begin
          up_q  <= 1'b1;
          count <= (period == '0) ? '0 : ONE;
        end else begin
          count <= count - ONE;
        end
      end
    end
  end

  assign count_up = updown & up_q;

  // R2: sawtooth wraps from zero to the period value
  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !sync && !updown && count == '0) |=> (count == $past(period)));

  // R3: rising phase of the triangle climbs by one
  a_r3_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !sync && count_up && count < period) |=> (count == $past(count) + ONE));

  // R11: sync clears the counter
  a_r11_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (count == '0));

  // R12: stopped counter holds
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !sync) |=> $stable(count));
endmodule

// File: rtl/pwm_evt_decode.sv
module pwm_evt_decode
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              updown,
  input  logic              count_up,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  output logic [NUM_EV-1:0] ev
);
  logic hit_a, hit_b;

  assign hit_a = run_en && (count == cmp_a);
  assign hit_b = run_en && (count == cmp_b);

  always_comb begin
    ev           = '0;
    ev[EV_ZERO]  = run_en && (count == '0);
    ev[EV_LOAD]  = run_en && (count == period);
    ev[EV_AUP]   = hit_a && count_up;
    ev[EV_ADOWN] = hit_a && !count_up;
    ev[EV_BUP]   = hit_b && count_up;
    ev[EV_BDOWN] = hit_b && !count_up;
  end

  // R6: no up-qualified compare events in sawtooth mode
  a_r6_no_up_sawtooth: assert property (@(posedge clk) disable iff (!rst_n)
    !updown |-> (!ev[EV_AUP] && !ev[EV_BUP]));

  // R12: a stopped timer emits no events
  a_r12_no_events: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (ev == '0));
endmodule

// File: rtl/pwm_evt_action.sv
module pwm_evt_action
  import pwm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic [ACT_W-1:0]  act,
  output logic              pwm_o
);
  act_e code;

  // later (higher-index) events overwrite earlier ones
  always_comb begin
    code = ACT_KEEP;
    for (int k = 0; k < NUM_EV; k++) begin
      if (ev[k] && act[2*k +: 2] != 2'b00) code = act_e'(act[2*k +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_o <= 1'b0;
    else        pwm_o <= apply_act(pwm_o, code);
  end

  // R7: without an event the output holds
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0) |=> $stable(pwm_o));

  // R7: a drive-high decision shows on the next cycle
  a_r7_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    (code == ACT_HIGH) |=> pwm_o);
endmodule

// File: rtl/pwm_evt_sel.sv
module pwm_evt_sel
  import pwm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic [NUM_EV-1:0] sel,
  output logic              hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= |(ev & sel);
  end

  // R9 and R10: no selected event, no pulse
  a_r9_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev & sel) == '0) |=> !hit);
endmodule

// File: rtl/pwm_event_gen.sv
module pwm_event_gen
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              updown,
  input  logic              sync,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic [ACT_W-1:0]  act_a,
  input  logic [ACT_W-1:0]  act_b,
  input  logic [NUM_EV-1:0] irq_sel,
  input  logic [NUM_EV-1:0] trig_sel,
  output logic [CNT_W-1:0]  count,
  output logic              count_up,
  output logic [NUM_EV-1:0] events,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              irq,
  output logic              adc_trig
);
  localparam int NUM_OUT = 2;

  logic [ACT_W-1:0]  act_tab [NUM_OUT];
  logic [NUM_EV-1:0] sel_tab [NUM_OUT];
  logic [NUM_OUT-1:0] pwm_vec;
  logic [NUM_OUT-1:0] pulse_vec;

  assign act_tab[0] = act_a;
  assign act_tab[1] = act_b;
  assign sel_tab[0] = irq_sel;
  assign sel_tab[1] = trig_sel;

  pwm_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .updown(updown), .sync(sync),
    .period(period), .count(count), .count_up(count_up)
  );

  pwm_evt_decode #(.CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .updown(updown),
    .count_up(count_up), .count(count), .period(period),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .ev(events)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    pwm_evt_action u_act (
      .clk(clk), .rst_n(rst_n), .ev(events), .act(act_tab[g]), .pwm_o(pwm_vec[g])
    );
    pwm_evt_sel u_sel (
      .clk(clk), .rst_n(rst_n), .ev(events), .sel(sel_tab[g]), .hit(pulse_vec[g])
    );
  end

  assign pwm_a    = pwm_vec[0];
  assign pwm_b    = pwm_vec[1];
  assign irq      = pulse_vec[0];
  assign adc_trig = pulse_vec[1];
endmodule

// File: tb/pwm_event_gen_test.sv
module pwm_event_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, updown = 1'b0, sync = 1'b0;
  logic [15:0] period = '0, cmp_a = '0, cmp_b = '0;
  logic [11:0] act_a = '0, act_b = '0;
  logic [5:0]  irq_sel = '0, trig_sel = '0;
  logic [15:0] count;
  logic        count_up, pwm_a, pwm_b, irq, adc_trig;
  logic [5:0]  events;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // model state
  logic [15:0] m_cnt = '0;
  logic        m_up = 1'b1, m_pa = 1'b0, m_pb = 1'b0, m_irq = 1'b0, m_trig = 1'b0;
  int          hi_a, hi_b;

  always #4 clk = ~clk;

  pwm_event_gen uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .updown(updown), .sync(sync),
    .period(period), .cmp_a(cmp_a), .cmp_b(cmp_b), .act_a(act_a), .act_b(act_b),
    .irq_sel(irq_sel), .trig_sel(trig_sel), .count(count), .count_up(count_up),
    .events(events), .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq), .adc_trig(adc_trig)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_dir();
    return updown & m_up;
  endfunction

  // R5, R6 event model
  function automatic logic [5:0] m_events();
    logic [5:0] e;
    logic d;
    d = m_dir();
    e[0] = run_en && m_cnt == 16'd0;
    e[1] = run_en && m_cnt == period;
    e[2] = run_en && m_cnt == cmp_a && d;
    e[3] = run_en && m_cnt == cmp_a && !d;
    e[4] = run_en && m_cnt == cmp_b && d;
    e[5] = run_en && m_cnt == cmp_b && !d;
    return e;
  endfunction

  // R7, R8: highest-index event with non-zero code decides
  function automatic logic m_resolve(input logic cur, input logic [11:0] act, input logic [5:0] e);
    for (int k = 5; k >= 0; k--) begin
      if (e[k] && act[2*k +: 2] != 2'd0) begin
        case (act[2*k +: 2])
          2'd1: return ~cur;
          2'd2: return 1'b0;
          default: return 1'b1;
        endcase
      end
    end
    return cur;
  endfunction

  task automatic tick();
    logic [5:0] e;
    #1;
    e = m_events();
    check("R2/R3/R11/R12 count", count, m_cnt);
    check("R4 count_up", {15'd0, count_up}, {15'd0, m_dir()});
    check("R5/R6 events", {10'd0, events}, {10'd0, e});
    check("R7/R8 pwm_a", {15'd0, pwm_a}, {15'd0, m_pa});
    check("R7/R8 pwm_b", {15'd0, pwm_b}, {15'd0, m_pb});
    check("R9 irq", {15'd0, irq}, {15'd0, m_irq});
    check("R10 adc_trig", {15'd0, adc_trig}, {15'd0, m_trig});
    hi_a += int'(pwm_a);
    hi_b += int'(pwm_b);
    m_pa   = m_resolve(m_pa, act_a, e);
    m_pb   = m_resolve(m_pb, act_b, e);
    m_irq  = |(e & irq_sel);
    m_trig = |(e & trig_sel);
    if (sync) begin
      m_cnt = '0; m_up = 1'b1;
    end else if (run_en) begin
      if (!updown) m_cnt = (m_cnt == 0) ? period : m_cnt - 16'd1;
      else if (m_up) begin
        if (m_cnt >= period) begin m_up = 1'b0; m_cnt = (period == 0) ? 16'd0 : period - 16'd1; end
        else m_cnt = m_cnt + 16'd1;
      end else begin
        if (m_cnt == 0) begin m_up = 1'b1; m_cnt = (period == 0) ? 16'd0 : 16'd1; end
        else m_cnt = m_cnt - 16'd1;
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 count", count, 16'd0);
    check("R1 count_up", {15'd0, count_up}, 16'd0);
    check("R1 events", {10'd0, events}, 16'd0);
    check("R1 pwm_a", {15'd0, pwm_a}, 16'd0);
    check("R1 pwm_b", {15'd0, pwm_b}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 adc_trig", {15'd0, adc_trig}, 16'd0);
    rst_n = 1'b1;

    // R13: duty cycle example in sawtooth mode
    period = 16'd399; cmp_a = 16'd299; cmp_b = 16'd99;
    act_a = 12'h08C; act_b = 12'h80C; updown = 1'b0;
    irq_sel = 6'b000001; trig_sel = 6'b000010;
    sync = 1'b1; run_en = 1'b1;
    tick();
    sync = 1'b0;
    for (int i = 0; i < 400; i++) tick();
    hi_a = 0; hi_b = 0;
    for (int i = 0; i < 400; i++) tick();
    check("R13 duty A high cycles", hi_a[15:0], 16'd100);
    check("R13 duty B high cycles", hi_b[15:0], 16'd300);

    // R8: compare-down beats load when both hit together
    period = 16'd4; cmp_a = 16'd4; act_a = 12'h08C;
    sync = 1'b1; tick(); sync = 1'b0;
    for (int i = 0; i < 30; i++) begin
      tick();
      check("R8 priority keeps pwm_a low", {15'd0, pwm_a}, 16'd0);
    end

    // R3: zero period in triangle mode stays at zero
    updown = 1'b1; period = 16'd0;
    sync = 1'b1; tick(); sync = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick();
      check("R3 zero period count", count, 16'd0);
    end

    // random configurations
    for (int c = 0; c < 40; c++) begin
      updown   = $urandom_range(0, 1);
      period   = 16'($urandom_range(0, 15));
      cmp_a    = 16'($urandom_range(0, 16));
      cmp_b    = 16'($urandom_range(0, 16));
      act_a    = 12'($urandom);
      act_b    = 12'($urandom);
      irq_sel  = 6'($urandom);
      trig_sel = 6'($urandom);
      for (int i = 0; i < 300; i++) begin
        sync   = ($urandom_range(0, 49) == 0);
        run_en = ($urandom_range(0, 9) != 0);
        tick();
      end
    end
    sync = 1'b0;

    // R12: stopped counter and silent events
    run_en = 1'b0;
    tick();
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R12 no events when stopped", {10'd0, events}, 16'd0);
    end

    finish_run();
  end
endmodule